// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a bank of up to 32 general-purpose pins behind a small 32-bit register bus. Each pin can serve as a general input, a general output, or an interrupt source. Software picks the role of each pin with one bit in a role register and one bit in a direction register. Output pads are shown as a value vector and an enable vector, so the pad ring can turn them into tri-state drivers. Input pads pass through a two-flop synchroniser before any logic uses them.

An interrupt pin can sense a level or an edge, with a selectable active sense. In edge mode it can also be set to react to both transitions. Sensed events land in a pending vector. Software acknowledges them by writing ones to a clear address. A mask vector that can be widened and narrowed through two separate addresses decides which pending bits reach the single request output. Bus accesses complete with a one-cycle ready pulse and registered read data.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0 at byte offsets 0x00, 0x04, 0x08, 0x0C (pins held low), 0x10, 0x18, 0x20, 0x24 and 0x4C, `pin_oe` is 0 and `irq` is 0.
- R2: A pin whose role bit (offset 0x00) is 0 and whose direction bit (offset 0x04) is 1 has its `pin_oe` bit set. `pin_out` equals the output register (offset 0x08), and that register reads back what was written.
- R3: Offset 0x0C returns the pin inputs through two synchronising flops: a read that commits on the second rising edge after a pin change still returns the old value, and a read that commits later returns the new one.
- R4: A pin whose role bit is 1 is an interrupt input and has `pin_oe` 0 whatever its direction bit holds.
- R5: In level mode (edge-select bit at 0x24 is 0) the pending bit (offset 0x10) tracks the synchronised pin XOR its sense bit (offset 0x20) every cycle, and a clear write cannot hold it at 0 while the level is active.
- R6: In edge mode (edge-select bit 1) with the both-edge bit (0x4C) at 0, a sense bit of 0 sets pending on a rising transition and a sense bit of 1 sets it on a falling transition. The bit stays set after the pin returns.
- R7: In edge mode with the both-edge bit at 1, either transition sets the pending bit and the sense bit has no effect.
- R8: Writing to offset 0x14 clears every pending bit written as 1. Bits written as 0 keep their value.
- R9: Writing to offset 0x1C sets the mask bits written as 1. Writing to offset 0x18 clears the mask bits written as 0 and keeps the bits written as 1. Offset 0x18 reads the mask, and offset 0x1C reads 0.
- R10: `irq` is 1 exactly when some bit is both pending and unmasked.
- R11: When an edge event and a clear write for the same pin fall on the same clock edge, the pending bit ends up set.
- R12: Every access with `bus_sel` high gets `bus_ready` high for exactly the following cycle. Read data is valid in that cycle.
- R13: A pin in the general role never shows a pending bit, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Access completion pulse |
| pin_in | input | NPINS | Asynchronous pad inputs |
| pin_out | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
Two things can land on the same pending bit in one clock edge: an edge event from a pin and a software clear of that bit. The bench sets this up by toggling an edge-mode pin at a known falling clock edge. It then times a write to the clear address so that the write commits on the third rising edge, which is the cycle in which the synchroniser and the previous-value flop report the transition. The bench then reads the pending register and expects the bit to still be set. A second clear must then remove it. The stickiness of edge bits without a clear, and level bits that stay set through a clear, are covered alongside.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_ready,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);

  localparam logic [AW-1:0] OFF_ROLE  = AW'(8'h00);
  localparam logic [AW-1:0] OFF_DIR   = AW'(8'h04);
  localparam logic [AW-1:0] OFF_DOUT  = AW'(8'h08);
  localparam logic [AW-1:0] OFF_DIN   = AW'(8'h0C);
  localparam logic [AW-1:0] OFF_PEND  = AW'(8'h10);
  localparam logic [AW-1:0] OFF_ACK   = AW'(8'h14);
  localparam logic [AW-1:0] OFF_MSKN  = AW'(8'h18);
  localparam logic [AW-1:0] OFF_MSKS  = AW'(8'h1C);
  localparam logic [AW-1:0] OFF_SENSE = AW'(8'h20);
  localparam logic [AW-1:0] OFF_EDGE  = AW'(8'h24);
  localparam logic [AW-1:0] OFF_BOTH  = AW'(8'h4C);

  logic [NPINS-1:0] role_q, dir_q, dout_q, mask_q, sense_q, edge_q, both_q, pend_q;
  logic [NPINS-1:0] sync1_q, sync2_q, prev_q;
  logic [NPINS-1:0] wd, ack_bits, rise, fall, edge_hit, level_on, pend_d;
  logic             wr;
  logic [31:0]      rd_mux;

  assign wr       = bus_sel & bus_we;
  assign wd       = bus_wdata[NPINS-1:0];
  assign ack_bits = (wr && bus_addr == OFF_ACK) ? wd : '0;

  assign rise     = sync2_q & ~prev_q;
  assign fall     = ~sync2_q & prev_q;
  assign edge_hit = (both_q & (rise | fall)) | (~both_q & ((~sense_q & rise) | (sense_q & fall)));
  assign level_on = sync2_q ^ sense_q;
  assign pend_d   = role_q & ((edge_q & ((pend_q & ~ack_bits) | edge_hit)) | (~edge_q & level_on));

  assign pin_out = dout_q;
  assign pin_oe  = ~role_q & dir_q;
  assign irq     = |(pend_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      pend_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      role_q  <= '0;
      dir_q   <= '0;
      dout_q  <= '0;
      mask_q  <= '0;
      sense_q <= '0;
      edge_q  <= '0;
      both_q  <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFF_ROLE:  role_q  <= wd;
        OFF_DIR:   dir_q   <= wd;
        OFF_DOUT:  dout_q  <= wd;
        OFF_MSKN:  mask_q  <= mask_q & wd;
        OFF_MSKS:  mask_q  <= mask_q | wd;
        OFF_SENSE: sense_q <= wd;
        OFF_EDGE:  edge_q  <= wd;
        OFF_BOTH:  both_q  <= wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFF_ROLE:  rd_mux[NPINS-1:0] = role_q;
      OFF_DIR:   rd_mux[NPINS-1:0] = dir_q;
      OFF_DOUT:  rd_mux[NPINS-1:0] = dout_q;
      OFF_DIN:   rd_mux[NPINS-1:0] = sync2_q;
      OFF_PEND:  rd_mux[NPINS-1:0] = pend_q;
      OFF_MSKN:  rd_mux[NPINS-1:0] = mask_q;
      OFF_SENSE: rd_mux[NPINS-1:0] = sense_q;
      OFF_EDGE:  rd_mux[NPINS-1:0] = edge_q;
      OFF_BOTH:  rd_mux[NPINS-1:0] = both_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_sel;
      bus_rdata <= (bus_sel && !bus_we) ? rd_mux : '0;
    end
  end

  a_r12_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ready);
  a_r12_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_ready);
  a_r6_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> (($past(pend_q & role_q & edge_q) & ~pend_q) == '0));
  a_r11_event_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFF_ACK) |=> (($past(edge_hit & role_q & edge_q) & ~pend_q) == '0));
  a_r13_general_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~role_q & $past(~role_q)) == '0);

endmodule

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
  localparam int NPINS = 32;
  localparam int AW    = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0]    bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             bus_ready;
  logic [NPINS-1:0] pin_in = '0;
  logic [NPINS-1:0] pin_out, pin_oe;
  logic             irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.NPINS(NPINS), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [7:0] offs [9] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h18, 8'h20, 8'h24, 8'h4C};
    foreach (offs[i]) begin
      bus_read(offs[i], d);
      chk("R1 register zero after reset", d, 32'h0);
    end
    chk("R1 pin_oe after reset", pin_oe, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_ready();
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 8'h00;
    chk("R12 ready low before edge", {31'h0, bus_ready}, 32'h0);
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R12 ready high after access", {31'h0, bus_ready}, 32'h1);
    @(negedge clk);
    chk("R12 ready lasts one cycle", {31'h0, bus_ready}, 32'h0);
  endtask

  task automatic t_output();
    logic [31:0] d;
    bus_write(8'h04, 32'h0000_00F0);
    bus_write(8'h08, 32'hA5A5_A5A5);
    chk("R2 pin_oe follows direction", pin_oe, 32'h0000_00F0);
    chk("R2 pin_out follows data", pin_out, 32'hA5A5_A5A5);
    bus_read(8'h08, d);
    chk("R2 output data readback", d, 32'hA5A5_A5A5);
    bus_write(8'h00, 32'h0000_0030);
    chk("R4 interrupt role disables driver", pin_oe, 32'h0000_00C0);
    bus_write(8'h00, 32'h0);
    bus_write(8'h04, 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk);
    pin_in = 32'h1234_5678;
    bus_read(8'h0C, d);
    chk("R3 second edge still old", d, 32'h0);
    bus_read(8'h0C, d);
    chk("R3 synchronised input", d, 32'h1234_5678);
    bus_read(8'h10, d);
    chk("R13 general pins never pend", d, 32'h0);
    pin_in = '0;
    wait_cyc(4);
  endtask

  task automatic t_level();
    logic [31:0] d;
    bus_write(8'h20, 32'h0);
    bus_write(8'h24, 32'h0);
    bus_write(8'h00, 32'h1);
    bus_write(8'h1C, 32'h1);
    wait_cyc(4);
    bus_read(8'h10, d);
    chk("R5 inactive level not pending", d, 32'h0);
    pin_in[0] = 1'b1;
    wait_cyc(4);
    bus_read(8'h10, d);
    chk("R5 high level pending", d, 32'h1);
    chk("R10 irq with unmasked pending", {31'h0, irq}, 32'h1);
    bus_write(8'h14, 32'h1);
    bus_read(8'h10, d);
    chk("R5 level survives clear", d, 32'h1);
    pin_in[0] = 1'b0;
    wait_cyc(4);
    bus_read(8'h10, d);
    chk("R5 level follows input low", d, 32'h0);
    chk("R10 irq drops", {31'h0, irq}, 32'h0);
    bus_write(8'h20, 32'h1);
    wait_cyc(2);
    bus_read(8'h10, d);
    chk("R5 active-low level pending", d, 32'h1);
    bus_write(8'h00, 32'h0);
    bus_write(8'h20, 32'h0);
    bus_write(8'h18, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    bus_write(8'h24, 32'h2);
    bus_write(8'h00, 32'h2);
    bus_write(8'h1C, 32'h2);
    pin_in[1] = 1'b1;
    wait_cyc(4);
    pin_in[1] = 1'b0;
    wait_cyc(4);
    bus_read(8'h10, d);
    chk("R6 rising edge sticky", d, 32'h2);
    bus_write(8'h14, 32'hFFFF_FFFD);
    bus_read(8'h10, d);
    chk("R8 zero bits leave pending", d, 32'h2);
    bus_write(8'h14, 32'h2);
    bus_read(8'h10, d);
    chk("R8 one bit clears pending", d, 32'h0);
    bus_write(8'h20, 32'h2);
    pin_in[1] = 1'b1;
    wait_cyc(4);
    bus_read(8'h10, d);
    chk("R6 falling sense ignores rise", d, 32'h0);
    pin_in[1] = 1'b0;
    wait_cyc(4);
    bus_read(8'h10, d);
    chk("R6 falling edge pending", d, 32'h2);
    bus_write(8'h14, 32'h2);
  endtask

  task automatic t_both();
    logic [31:0] d;
    bus_write(8'h4C, 32'h2);
    pin_in[1] = 1'b1;
    wait_cyc(4);
    bus_read(8'h10, d);
    chk("R7 both-edge rise pending", d, 32'h2);
    bus_write(8'h14, 32'h2);
    pin_in[1] = 1'b0;
    wait_cyc(4);
    bus_read(8'h10, d);
    chk("R7 both-edge fall pending", d, 32'h2);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bus_write(8'h18, 32'h0);
    bus_read(8'h18, d);
    chk("R9 mask cleared by zeros", d, 32'h0);
    chk("R10 pending but masked", {31'h0, irq}, 32'h0);
    bus_write(8'h1C, 32'h0000_000F);
    bus_read(8'h18, d);
    chk("R9 mask set", d, 32'h0000_000F);
    chk("R10 irq once unmasked", {31'h0, irq}, 32'h1);
    bus_write(8'h18, 32'hFFFF_FFF9);
    bus_read(8'h18, d);
    chk("R9 mask narrowed", d, 32'h0000_0009);
    chk("R10 irq off with pin masked", {31'h0, irq}, 32'h0);
    bus_read(8'h1C, d);
    chk("R9 set address reads zero", d, 32'h0);
    bus_write(8'h14, 32'h2);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    bus_write(8'h4C, 32'h0);
    bus_write(8'h20, 32'h0);
    bus_write(8'h24, 32'h4);
    bus_write(8'h00, 32'h4);
    pin_in[2] = 1'b1;
    @(negedge clk);
    bus_write(8'h14, 32'h4);
    bus_read(8'h10, d);
    chk("R11 event beats same-cycle clear", d, 32'h4);
    bus_write(8'h14, 32'h4);
    bus_read(8'h10, d);
    chk("R11 later clear removes bit", d, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    t_reset();
    t_ready();
    t_output();
    t_input();
    t_level();
    t_edge();
    t_both();
    t_mask();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule